// File: doc/BRIEF.md
# Pipelined Four-Master Bus Arbiter

This block decides which of four bus masters drives the next address phase of a shared internal bus. It holds an arbitration pointer that names the master next in line. If that master is requesting while the address phase is free, it wins at once. Every other requester first has to move the pointer onto itself, which costs at least one more pipeline stage.

Each cycle, the arbiter recomputes the pointer from the requesters that are not being served in that cycle. Configuration chooses between two selection rules. The first is a fixed ranking where the higher index wins. The second is a rotating ranking that shifts with the current bus owner. A parking bit decides where the pointer goes when nobody requests.

Each master has a wait counter that measures how long its request has gone unserved. When any counter reaches a programmable limit, the fixed ranking is overridden by the rotating rule until that master is served.

Top module: `shared_bus_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `owner` is 0, all wait counts are 0, and the pointer names M0. Master M0 requesting with `addr_free` high on the first cycle after reset is granted at the next clock edge.
- R2: `grant` never has more than one bit set. Bit i means master Mi (i = 0..3) owns the address phase starting in that cycle. A grant lasts exactly one cycle per address phase.
- R3: If a clock edge samples `addr_free` high and `req[p]` high, where p is the pointer, then after that edge `grant` has only bit p set and `owner` equals p. Otherwise `grant` is 0 after the edge.
- R4: A requester that is not under the pointer is never granted at the next edge. It is granted no earlier than the edge after the pointer has moved to it.
- R5: With fixed selection, the next pointer is the highest-index requester among those not being granted at that edge. M3 ranks highest and M0 lowest.
- R6: With rotating selection, requester i ranks as (i + c) mod 4, and the highest rank becomes the next pointer. Here c is the master granted at that edge, or `owner` if no grant is made at that edge.
- R7: At an edge with no request at all, the pointer moves to M0 if `park_low` is 1, and keeps its value if `park_low` is 0. At an edge where only the granted master requests, the pointer keeps its value.
- R8: A master's wait count rises by 1 at each edge where it requests and is not granted, saturating at its maximum. The count clears otherwise. While any requesting master's count is at least `starve_limit`, the rotating rule of R6 is used even when `rr_mode` is 0.
- R9: `owner` changes only at an edge that issues a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_MST | Per-master bus request |
| addr_free | input | 1 | Address phase can start this cycle |
| rr_mode | input | 1 | 1 selects rotating ranking, 0 selects fixed ranking |
| park_low | input | 1 | Idle policy: 1 parks the pointer on M0, 0 holds it |
| starve_limit | input | CNT_W | Wait count that forces rotating ranking |
| grant | output | N_MST | One-hot address-phase grant, registered |
| owner | output | IDX_W | Index of the current bus owner, registered |

## Verification
The checker examines several properties on every cycle:
- `grant` has at most one bit set.
- Every grant traces back to the pointer and a free address phase at the previous edge.
- `owner` matches any active grant and holds steady between grants.
- The idle parking policy moves the pointer as configured.
- Reset produces the cleared state.

The ranking rules need the bench's reference model driven with random and directed traffic. The rotating arithmetic, the extra stage for a requester off the pointer, and the starvation override switching rules mid-sequence can only be seen in the order of grants over several cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    RANK_FIXED  = 1'b0,
    RANK_ROTATE = 1'b1
  } rank_mode_e;
endpackage

// File: rtl/arb_pick.sv
// Selects the best candidate under fixed or rotating ranking.
module arb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic          rotate,
  input  logic [IW-1:0] cur,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    // walk ranks from highest to lowest; map rank back to a master index
    for (int k = N - 1; k >= 0; k--) begin
      int unsigned pos;
      if (rotate) pos = (int'(k) + N - int'(cur)) % N;
      else        pos = k;
      if (!found && cand[pos[IW-1:0]]) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_wait_ctr.sv
// Per-master wait counter with a starvation flag.
module arb_wait_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             served,
  input  logic [CNT_W-1:0] limit,
  output logic             starved
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (pending && !served) begin
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign starved = pending && (cnt_q >= limit);
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int N_MST = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  input  logic             addr_free,
  input  logic             rr_mode,
  input  logic             park_low,
  input  logic [CNT_W-1:0] starve_limit,
  output logic [N_MST-1:0] grant,
  output logic [IDX_W-1:0] owner
);
  import arb_pkg::*;

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] owner_q;
  logic [N_MST-1:0] grant_q;

  logic             hit;
  logic [N_MST-1:0] served_vec;
  logic [N_MST-1:0] remaining;
  logic [N_MST-1:0] starved_vec;
  logic [IDX_W-1:0] cur_master;
  rank_mode_e       rank_sel;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  // zero-latency hit: pointer's master requests and the address phase is open
  assign hit = addr_free && req[ptr_q];

  always_comb begin
    served_vec = '0;
    if (hit) served_vec[ptr_q] = 1'b1;
  end

  assign remaining  = req & ~served_vec;
  assign cur_master = hit ? ptr_q : owner_q;
  assign rank_sel   = (rr_mode || (|starved_vec)) ? RANK_ROTATE : RANK_FIXED;

  genvar g;
  generate
    for (g = 0; g < N_MST; g++) begin : g_wait
      arb_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .pending (req[g]),
        .served  (served_vec[g]),
        .limit   (starve_limit),
        .starved (starved_vec[g])
      );
    end
  endgenerate

  arb_pick #(.N(N_MST), .IW(IDX_W)) u_pick (
    .cand   (remaining),
    .rotate (rank_sel == RANK_ROTATE),
    .cur    (cur_master),
    .found  (pick_found),
    .idx    (pick_idx)
  );

  always_comb begin
    if (pick_found)          ptr_d = pick_idx;
    else if (req == '0)      ptr_d = park_low ? '0 : ptr_q;
    else                     ptr_d = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      owner_q <= '0;
      grant_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      grant_q <= served_vec;
      if (hit) owner_q <= ptr_q;
    end
  end

  assign grant = grant_q;
  assign owner = owner_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req,
  input logic          addr_free,
  input logic          park_low,
  input logic [N-1:0]  grant,
  input logic [IW-1:0] owner,
  input logic [IW-1:0] ptr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (grant == '0 && owner == '0 && ptr == '0));

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  grant_source_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (grant[$past(ptr)] && $past(addr_free)));

  // R3
  owner_match_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> grant[owner]);

  // R9
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |-> $stable(owner));

  // R7
  park_low_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && park_low) |=> (ptr == '0));

  // R7
  park_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && !park_low) |=> $stable(ptr));
endmodule

bind shared_bus_arbiter arb_checker #(.N(N_MST), .IW(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .addr_free (addr_free),
  .park_low  (park_low),
  .grant     (grant),
  .owner     (owner),
  .ptr       (ptr_q)
);

// File: tb/tb_shared_bus_arbiter.sv
module tb_shared_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NM-1:0] req;
  logic          addr_free;
  logic          rr_mode;
  logic          park_low;
  logic [CW-1:0] starve_limit;
  logic [NM-1:0] grant;
  logic [1:0]    owner;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_arbiter #(.N_MST(NM), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .req(req), .addr_free(addr_free),
    .rr_mode(rr_mode), .park_low(park_low), .starve_limit(starve_limit),
    .grant(grant), .owner(owner)
  );

  // reference model of the requirements
  logic [1:0]    m_ptr, m_owner;
  logic [NM-1:0] m_grant;
  int            m_cnt [NM];

  always @(posedge clk) begin : model
    logic       h;
    logic [1:0] c;
    logic       rot;
    int         best, bestp, p;
    logic [NM-1:0] rem;
    if (rst) begin
      m_ptr <= 2'd0; m_owner <= 2'd0; m_grant <= '0;
      for (int i = 0; i < NM; i++) m_cnt[i] <= 0;
    end else begin
      h   = addr_free && req[m_ptr];
      c   = h ? m_ptr : m_owner;
      rot = rr_mode;
      for (int i = 0; i < NM; i++)
        if (req[i] && m_cnt[i] >= int'(starve_limit)) rot = 1'b1;
      rem = req;
      if (h) rem[m_ptr] = 1'b0;
      best = -1; bestp = -1;
      for (int i = 0; i < NM; i++) begin
        if (rem[i]) begin
          p = rot ? (i + int'(c)) % NM : i;
          if (p > bestp) begin bestp = p; best = i; end
        end
      end
      if (best >= 0)                 m_ptr <= best[1:0];
      else if (req == '0 && park_low) m_ptr <= 2'd0;
      for (int i = 0; i < NM; i++) begin
        if (req[i] && !(h && int'(m_ptr) == i))
          m_cnt[i] <= (m_cnt[i] < 255) ? m_cnt[i] + 1 : 255;
        else
          m_cnt[i] <= 0;
      end
      m_grant <= h ? (NM'(1) << m_ptr) : '0;
      if (h) m_owner <= m_ptr;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; addr_free = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic set(logic [NM-1:0] r, logic af);
    req = r; addr_free = af;
  endtask

  initial begin
    rst = 1'b1; req = '0; addr_free = 1'b0; rr_mode = 1'b0;
    park_low = 1'b0; starve_limit = 8'd255;
    void'($urandom(1234));
    @(negedge clk);
    do_reset();

    // R1 reset state and pointer on M0
    chk("R1 grant", grant, 0);
    chk("R1 owner", owner, 0);
    set(4'b0001, 1'b1); tick();
    chk("R1 first grant M0", grant, 4'b0001);

    // R4 requester off the pointer needs an extra stage
    do_reset();
    set(4'b1000, 1'b1); tick();
    chk("R4 no grant yet", grant, 0);
    tick();
    chk("R4 grant M3", grant, 4'b1000);
    chk("R3 owner M3", owner, 3);

    // R5 fixed ranking excludes the served master
    do_reset();
    set(4'b0111, 1'b1); tick();
    chk("R5 first", grant, 4'b0001);
    set(4'b0110, 1'b1); tick();
    chk("R5 highest remaining", grant, 4'b0100);

    // R6 rotating vs fixed with all requesting
    do_reset(); rr_mode = 1'b1;
    set(4'b1111, 1'b1); tick();
    chk("R6 g1", grant, 4'b0001); tick();
    chk("R6 g2", grant, 4'b1000); tick();
    chk("R6 g3 wraps to M0", grant, 4'b0001);
    do_reset(); rr_mode = 1'b0;
    set(4'b1111, 1'b1); tick(); tick(); tick();
    chk("R5 fixed g3", grant, 4'b0100);

    // R7 idle keep
    do_reset(); park_low = 1'b0;
    set(4'b1000, 1'b0); tick();
    set(4'b0000, 1'b0); tick();
    chk("R7 idle no grant", grant, 0);
    set(4'b1001, 1'b1); tick();
    chk("R7 keep pointer", grant, 4'b1000);
    // R7 idle park low
    do_reset(); park_low = 1'b1;
    set(4'b1000, 1'b0); tick();
    set(4'b0000, 1'b0); tick();
    set(4'b1001, 1'b1); tick();
    chk("R7 park on M0", grant, 4'b0001);
    park_low = 1'b0;

    // R8 starvation override
    do_reset(); starve_limit = 8'd3;
    set(4'b1110, 1'b1);
    for (int k = 0; k < 5; k++) tick();
    chk("R8 pre-override M2", grant, 4'b0100);
    tick();
    chk("R8 starved M1 served", grant, 4'b0010);
    do_reset(); starve_limit = 8'd255;
    set(4'b1110, 1'b1);
    for (int k = 0; k < 6; k++) tick();
    chk("R8 no override M3", grant, 4'b1000);

    // random traffic against the model
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      req       = NM'($urandom_range(0, 15));
      addr_free = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 49) == 0) rr_mode  = ~rr_mode;
      if ($urandom_range(0, 49) == 0) park_low = ~park_low;
      if ($urandom_range(0, 99) == 0) starve_limit = CW'($urandom_range(0, 12));
      if ($urandom_range(0, 3) == 0) req = '0;
      tick();
      chk("R3 R5 R6 R8 grant", grant, m_grant);
      chk("R9 owner", owner, m_owner);
      chk("R2 onehot", int'($countones(grant) <= 1), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule